// File: doc/BRIEF.md
# Processor Reset and Exception Sequencer

This block decides where a small 32-bit pipelined RISC core fetches next when a reset or a hardware exception happens. A reset is accepted only after it has been held long enough. An accepted reset sends fetch to the vector base. It also loads the machine status register from per-bit parameters and clears the fault-side registers and the load reservation.

A hardware exception works as follows:
- The block picks one request by a fixed priority.
- It flushes the pipeline and stops the execute-stage instruction from committing.
- It sends fetch to the vector base plus 0x20.
- It records a cause code.
- It marks an exception as in progress.

For memory-management faults it also produces the value for the link register (R17). That value is moved back over an immediate-prefix instruction, or out of a branch delay slot to the branch, so that the faulting instruction runs again on return.

The status and fault registers can also be written through a simple select/data port. This lets system code restore them, and it lets their reset clearing be observed.

Top module: `exc_seq`

## Requirements
- R1: Both reset inputs (`rst_sys`, `rst_dbg`) are active high and act the same way. A qualified reset asserts `flush` and `redirect`, with `redirect_pc` = `BASE_VEC`.
- R2: A reset counts only in the 16th consecutive cycle in which either reset input is high, and in every later cycle it stays high. A shorter pulse changes no output and no register.
- R3: After a qualified reset, `msr` holds `RST_IE` at bit 2, `RST_BIP` at bit 4, `RST_ICE` at bit 6, `RST_DCE` at bit 8, `RST_EE` at bit 9 and `RST_EIP` at bit 10, with every other bit 0.
- R4: After a qualified reset, `ear`, `esr`, `fsr`, `pid`, `zpr` and `tlbx` read 0, and `resv` reads 0.
- R5: A taken exception asserts `flush`, `redirect` and `kill_ex` in the same cycle, with `redirect_pc` = `BASE_VEC` + 0x20.
- R6: For a memory-management exception, `link_we` is high and `link_val` = `ex_pc`. No other exception class raises `link_we`.
- R7: If `ex_has_imm` is high and `ex_in_delay` is low, `link_val` = `ex_pc` − 4.
- R8: If `ex_in_delay` is high, `link_val` = `ex_pc` − 4. It is `ex_pc` − 8 when `br_has_imm` is also high. `ex_has_imm` is then ignored.
- R9: `req_div` is honoured only when `HAS_DIV` is 1. Otherwise it causes no exception.
- R10: Priority runs as follows, and the winner's cause code goes into `esr[4:0]` at the next clock edge:
  - `req_mmu[0]` (0x10), `req_mmu[1]` (0x11), `req_mmu[2]` (0x12), `req_mmu[3]` (0x13)
  - `req_bus[0]` (0x03), `req_bus[1]` (0x04)
  - `req_ill` (0x01), `req_unal` (0x02)
  - `req_div` (0x05), `req_fp` (0x06)
  
  A qualified reset overrides any exception.
- R11: A taken exception sets `msr[10]` and clears `msr[9]`. While `msr[10]` is 1, every exception request is ignored.
- R12: When `sr_we` is high, `sr_wdata` is written at the clock edge to the register picked by `sr_sel`: 0 `msr`, 1 `ear`, 2 `esr`, 3 `fsr`, 4 `pid`, 5 `zpr`, 6 `tlbx`. `resv_set` sets `resv` and `resv_clr` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_sys | input | 1 | System reset request, active high |
| rst_dbg | input | 1 | Debugger reset request, active high |
| req_mmu | input | 4 | Data storage, instruction storage, data TLB miss, instruction TLB miss |
| req_bus | input | 2 | Instruction bus error, data bus error |
| req_ill | input | 1 | Illegal instruction |
| req_unal | input | 1 | Unaligned access |
| req_div | input | 1 | Divide by zero |
| req_fp | input | 1 | Floating-point exception |
| ex_pc | input | 32 | PC of the execute-stage instruction |
| ex_has_imm | input | 1 | Execute instruction follows an immediate prefix |
| ex_in_delay | input | 1 | Execute instruction sits in a branch delay slot |
| br_has_imm | input | 1 | The owning branch follows an immediate prefix |
| sr_we | input | 1 | Status register write enable |
| sr_sel | input | 3 | Status register select |
| sr_wdata | input | 32 | Status register write data |
| resv_set | input | 1 | Set load reservation |
| resv_clr | input | 1 | Clear load reservation |
| flush | output | 1 | Flush the pipeline |
| redirect | output | 1 | Load `redirect_pc` into the fetch PC |
| redirect_pc | output | 32 | New fetch address |
| kill_ex | output | 1 | Suppress commit of the execute-stage instruction |
| link_we | output | 1 | Write `link_val` to R17 |
| link_val | output | 32 | Return address |
| msr | output | 32 | Machine status register |
| ear | output | 32 | Exception address register |
| esr | output | 32 | Exception status register |
| fsr | output | 32 | Floating-point status register |
| pid | output | 32 | Process ID |
| zpr | output | 32 | Zone protection register |
| tlbx | output | 32 | TLB index |
| resv | output | 1 | Load reservation flag |

## Verification
A wrong reset-hold count shows up on the exact cycle that `flush` rises: it comes one cycle early or late against the 16th asserted cycle. A reset that was skipped leaves the values written earlier visible on the register outputs one cycle later. A wrong priority or return-address choice is visible in the same cycle on `link_val`, `link_we` and `kill_ex`, and at the next edge on `esr`. A stuck exception-in-progress bit is caught on the very next request, because `kill_ex` then stays low.

// File: rtl/exc_seq.sv
module exc_seq #(
  parameter logic [31:0] BASE_VEC = 32'h0,
  parameter bit RST_IE  = 1'b0,
  parameter bit RST_BIP = 1'b0,
  parameter bit RST_ICE = 1'b0,
  parameter bit RST_DCE = 1'b0,
  parameter bit RST_EE  = 1'b0,
  parameter bit RST_EIP = 1'b0,
  parameter bit HAS_DIV = 1'b1,
  parameter int HOLD    = 16
) (
  input  logic        clk,
  input  logic        rst_sys,
  input  logic        rst_dbg,
  input  logic [3:0]  req_mmu,
  input  logic [1:0]  req_bus,
  input  logic        req_ill,
  input  logic        req_unal,
  input  logic        req_div,
  input  logic        req_fp,
  input  logic [31:0] ex_pc,
  input  logic        ex_has_imm,
  input  logic        ex_in_delay,
  input  logic        br_has_imm,
  input  logic        sr_we,
  input  logic [2:0]  sr_sel,
  input  logic [31:0] sr_wdata,
  input  logic        resv_set,
  input  logic        resv_clr,
  output logic        flush,
  output logic        redirect,
  output logic [31:0] redirect_pc,
  output logic        kill_ex,
  output logic        link_we,
  output logic [31:0] link_val,
  output logic [31:0] msr,
  output logic [31:0] ear,
  output logic [31:0] esr,
  output logic [31:0] fsr,
  output logic [31:0] pid,
  output logic [31:0] zpr,
  output logic [31:0] tlbx,
  output logic        resv
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);
  localparam logic [31:0] MSR_RST = (32'(RST_IE) << 2) | (32'(RST_BIP) << 4) |
    (32'(RST_ICE) << 6) | (32'(RST_DCE) << 8) | (32'(RST_EE) << 9) | (32'(RST_EIP) << 10);
  localparam logic [31:0] EXC_VEC = BASE_VEC + 32'h20;

  logic [CW-1:0] rcnt;
  logic [4:0]    cause;
  logic [1:0]    back;

  wire any_rst = rst_sys | rst_dbg;
  wire rst_ok  = any_rst && (rcnt == LAST);
  wire div_ok  = req_div & HAS_DIV;
  wire hit     = (|req_mmu) | (|req_bus) | req_ill | req_unal | div_ok | req_fp;
  wire take    = hit && !msr[10] && !rst_ok;

  always_ff @(posedge clk)
    if (!any_rst) rcnt <= '0;
    else if (rcnt != LAST) rcnt <= rcnt + 1'b1;

  always_comb begin
    if      (req_mmu[0]) cause = 5'h10;
    else if (req_mmu[1]) cause = 5'h11;
    else if (req_mmu[2]) cause = 5'h12;
    else if (req_mmu[3]) cause = 5'h13;
    else if (req_bus[0]) cause = 5'h03;
    else if (req_bus[1]) cause = 5'h04;
    else if (req_ill)    cause = 5'h01;
    else if (req_unal)   cause = 5'h02;
    else if (div_ok)     cause = 5'h05;
    else                 cause = 5'h06;
  end

  always_comb begin
    if (ex_in_delay) back = br_has_imm ? 2'd2 : 2'd1;
    else             back = ex_has_imm ? 2'd1 : 2'd0;
  end

  assign flush       = rst_ok | take;
  assign redirect    = flush;
  assign redirect_pc = rst_ok ? BASE_VEC : EXC_VEC;
  assign kill_ex     = take;
  assign link_we     = take && (|req_mmu);
  assign link_val    = ex_pc - {28'b0, back, 2'b00};

  always_ff @(posedge clk) begin
    if (rst_ok) begin
      msr  <= MSR_RST;
      ear  <= '0;
      esr  <= '0;
      fsr  <= '0;
      pid  <= '0;
      zpr  <= '0;
      tlbx <= '0;
      resv <= 1'b0;
    end else begin
      if (sr_we)
        case (sr_sel)
          3'd0: msr  <= sr_wdata;
          3'd1: ear  <= sr_wdata;
          3'd2: esr  <= sr_wdata;
          3'd3: fsr  <= sr_wdata;
          3'd4: pid  <= sr_wdata;
          3'd5: zpr  <= sr_wdata;
          3'd6: tlbx <= sr_wdata;
          default: ;
        endcase
      if (resv_set) resv <= 1'b1;
      if (resv_clr) resv <= 1'b0;
      if (take) begin
        esr     <= {27'b0, cause};
        msr[10] <= 1'b1;
        msr[9]  <= 1'b0;
      end
    end
  end
endmodule

module exc_seq_chk #(
  parameter logic [31:0] BASE_VEC = 32'h0,
  parameter logic [31:0] MSR_RST  = 32'h0,
  parameter int HOLD = 16
) (
  input logic        clk,
  input logic        rst_sys,
  input logic        rst_dbg,
  input logic        flush,
  input logic        kill_ex,
  input logic        link_we,
  input logic [31:0] redirect_pc,
  input logic [31:0] msr
);
  localparam int CW = $clog2(HOLD + 2);
  logic [CW-1:0] held = '0;
  logic seen = 1'b0;

  always_ff @(posedge clk) begin
    if (!(rst_sys | rst_dbg)) held <= '0;
    else if (held != CW'(HOLD)) held <= held + 1'b1;
    if (flush && !kill_ex) seen <= 1'b1;
  end

  assert_reset_hold_R2: assert property (@(posedge clk)
    (flush && !kill_ex) |-> (held >= CW'(HOLD - 1)));

  assert_reset_vec_R1: assert property (@(posedge clk) disable iff (!seen)
    (flush && !kill_ex) |-> (redirect_pc == BASE_VEC));

  assert_msr_reset_R3: assert property (@(posedge clk)
    (flush && !kill_ex) |=> (msr == MSR_RST));

  assert_exc_vec_R5: assert property (@(posedge clk) disable iff (!seen)
    kill_ex |-> (flush && redirect_pc == BASE_VEC + 32'h20));

  assert_link_only_exc_R6: assert property (@(posedge clk) disable iff (!seen)
    link_we |-> kill_ex);

  assert_eip_set_R11: assert property (@(posedge clk) disable iff (!seen)
    kill_ex |=> (msr[10] && !msr[9]));

  assert_eip_masks_R11: assert property (@(posedge clk) disable iff (!seen)
    msr[10] |-> !kill_ex);
endmodule

bind exc_seq exc_seq_chk #(.BASE_VEC(BASE_VEC), .MSR_RST(MSR_RST), .HOLD(HOLD)) u_chk (
  .clk(clk), .rst_sys(rst_sys), .rst_dbg(rst_dbg), .flush(flush), .kill_ex(kill_ex),
  .link_we(link_we), .redirect_pc(redirect_pc), .msr(msr)
);

// File: tb/exc_seq_bench.sv
module exc_seq_bench;
  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam logic [31:0] MSR_EXP = 32'h0000_0244;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_sys = 0, rst_dbg = 0;
  logic [3:0] req_mmu = 0;
  logic [1:0] req_bus = 0;
  logic req_ill = 0, req_unal = 0, req_div = 0, req_fp = 0;
  logic [31:0] ex_pc = 0;
  logic ex_has_imm = 0, ex_in_delay = 0, br_has_imm = 0;
  logic sr_we = 0;
  logic [2:0] sr_sel = 0;
  logic [31:0] sr_wdata = 0;
  logic resv_set = 0, resv_clr = 0;

  logic flush, redirect, kill_ex, link_we, resv;
  logic [31:0] redirect_pc, link_val, msr, ear, esr, fsr, pid, zpr, tlbx;
  logic flush2, redirect2, kill2, lwe2, resv2;
  logic [31:0] rpc2, lval2, msr2, ear2, esr2, fsr2, pid2, zpr2, tlbx2;

  exc_seq #(.BASE_VEC(BASE), .RST_IE(1), .RST_ICE(1), .RST_EE(1), .HAS_DIV(0)) u_exc_seq (
    .clk, .rst_sys, .rst_dbg, .req_mmu, .req_bus, .req_ill, .req_unal, .req_div, .req_fp,
    .ex_pc, .ex_has_imm, .ex_in_delay, .br_has_imm, .sr_we, .sr_sel, .sr_wdata,
    .resv_set, .resv_clr, .flush, .redirect, .redirect_pc, .kill_ex, .link_we, .link_val,
    .msr, .ear, .esr, .fsr, .pid, .zpr, .tlbx, .resv);

  exc_seq #(.BASE_VEC(BASE), .RST_IE(1), .RST_ICE(1), .RST_EE(1), .HAS_DIV(1)) u_exc_seq_div (
    .clk, .rst_sys, .rst_dbg, .req_mmu, .req_bus, .req_ill, .req_unal, .req_div, .req_fp,
    .ex_pc, .ex_has_imm, .ex_in_delay, .br_has_imm, .sr_we, .sr_sel, .sr_wdata,
    .resv_set, .resv_clr, .flush(flush2), .redirect(redirect2), .redirect_pc(rpc2),
    .kill_ex(kill2), .link_we(lwe2), .link_val(lval2), .msr(msr2), .ear(ear2), .esr(esr2),
    .fsr(fsr2), .pid(pid2), .zpr(zpr2), .tlbx(tlbx2), .resv(resv2));

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk); #1;
  endtask

  task automatic sr_write(logic [2:0] sel, logic [31:0] d);
    sr_we = 1; sr_sel = sel; sr_wdata = d;
    cyc();
    sr_we = 0;
  endtask

  function automatic logic [4:0] exp_cause(logic [9:0] v);
    if (v[9]) return 5'h10;
    if (v[8]) return 5'h11;
    if (v[7]) return 5'h12;
    if (v[6]) return 5'h13;
    if (v[5]) return 5'h03;
    if (v[4]) return 5'h04;
    if (v[3]) return 5'h01;
    if (v[2]) return 5'h02;
    if (v[1]) return 5'h05;
    return 5'h06;
  endfunction

  task automatic set_req(logic [9:0] v);
    req_mmu = {v[6], v[7], v[8], v[9]};
    req_bus = {v[4], v[5]};
    req_ill = v[3]; req_unal = v[2]; req_div = v[1]; req_fp = v[0];
  endtask

  initial begin
    @(negedge clk); @(negedge clk); #1;
    // R1, R2: system reset held exactly 16 cycles
    rst_sys = 1;
    for (int i = 0; i < 16; i++) begin
      if (i < 15) chk("R2 early flush", {31'b0, flush}, 0);
      else begin
        chk("R1 flush", {31'b0, flush & redirect}, 1);
        chk("R1 reset pc", redirect_pc, BASE);
      end
      cyc();
    end
    rst_sys = 0;
    chk("R3 msr reset", msr, MSR_EXP);
    chk("R4 esr reset", esr, 0);
    chk("R4 resv reset", {31'b0, resv}, 0);

    // R12: write every register, set reservation
    for (int s = 0; s < 7; s++) sr_write(3'(s), 32'hA500_0000 + 32'(s));
    resv_set = 1; cyc(); resv_set = 0;
    chk("R12 pid write", pid, 32'hA500_0004);
    chk("R12 tlbx write", tlbx, 32'hA500_0006);
    chk("R12 resv set", {31'b0, resv}, 1);
    resv_clr = 1; cyc(); resv_clr = 0;
    chk("R12 resv clr", {31'b0, resv}, 0);
    resv_set = 1; cyc(); resv_set = 0;

    // R2: 15-cycle debug reset has no effect
    rst_dbg = 1;
    for (int i = 0; i < 15; i++) begin
      chk("R2 short flush", {31'b0, flush}, 0);
      cyc();
    end
    rst_dbg = 0; cyc();
    chk("R2 short msr kept", msr, 32'hA500_0000);
    chk("R2 short ear kept", ear, 32'hA500_0001);
    chk("R2 short zpr kept", zpr, 32'hA500_0005);
    chk("R2 short resv kept", {31'b0, resv}, 1);

    // R1, R4: debugger reset, held 20 cycles
    rst_dbg = 1;
    for (int i = 0; i < 20; i++) begin
      if (i >= 15) chk("R1 dbg flush", {31'b0, flush}, 1);
      else chk("R2 dbg early", {31'b0, flush}, 0);
      cyc();
    end
    rst_dbg = 0;
    chk("R3 msr dbg reset", msr, MSR_EXP);
    chk("R4 ear", ear, 0); chk("R4 esr", esr, 0); chk("R4 fsr", fsr, 0);
    chk("R4 pid", pid, 0); chk("R4 zpr", zpr, 0); chk("R4 tlbx", tlbx, 0);
    chk("R4 resv", {31'b0, resv}, 0);

    // R6, R7, R8: return address sweep over all MMU types and flag combinations
    for (int t = 0; t < 4; t++)
      for (int f = 0; f < 8; f++) begin
        logic [31:0] pc, exp;
        int steps;
        pc = 32'h0000_2000 + 32'(t * 256 + f * 16);
        ex_pc = pc; ex_has_imm = f[0]; ex_in_delay = f[1]; br_has_imm = f[2];
        steps = f[1] ? (f[2] ? 2 : 1) : (f[0] ? 1 : 0);
        exp = pc - 32'(4 * steps);
        req_mmu = 4'(1 << t);
        #1;
        chk("R5 kill", {31'b0, kill_ex}, 1);
        chk("R5 vector", redirect_pc, BASE + 32'h20);
        chk("R6 link_we", {31'b0, link_we}, 1);
        chk(f[1] ? "R8 delay link" : (f[0] ? "R7 imm link" : "R6 link"), link_val, exp);
        cyc();
        req_mmu = 0;
        chk("R10 mmu cause", esr, 32'h10 + 32'(t));
        chk("R11 eip set", {30'b0, msr[10], msr[9]}, 2);
        sr_write(0, 0);
      end
    ex_has_imm = 0; ex_in_delay = 0; br_has_imm = 0;

    // R9, R10, R6: full priority sweep
    for (int v = 1; v < 1024; v++) begin
      logic [9:0] vv;
      logic fires;
      vv = 10'(v);
      fires = (vv & 10'b11_1111_1101) != 0;
      set_req(vv);
      #1;
      chk("R9 R10 taken", {31'b0, kill_ex}, {31'b0, fires});
      chk("R10 div build taken", {31'b0, kill2}, 1);
      chk("R6 link class", {31'b0, link_we}, {31'b0, fires && vv[9:6] != 0});
      cyc();
      set_req(0);
      if (fires) chk("R10 cause", esr, {27'b0, exp_cause(vv & 10'b11_1111_1101)});
      chk("R9 div build cause", esr2, {27'b0, exp_cause(vv)});
      sr_write(0, 0);
    end

    // R11: masking while exception in progress
    set_req(10'h008); #1;
    chk("R11 first taken", {31'b0, kill_ex}, 1);
    cyc();
    set_req(10'h200); #1;
    chk("R11 masked", {31'b0, kill_ex}, 0);
    cyc();
    set_req(0);
    chk("R11 esr unchanged", esr, 32'h01);

    // R10: reset overrides a pending exception
    sr_write(0, 0);
    rst_sys = 1; set_req(10'h008);
    for (int i = 0; i < 16; i++) begin
      if (i == 15) begin
        chk("R10 reset wins kill", {31'b0, kill_ex}, 0);
        chk("R10 reset wins pc", redirect_pc, BASE);
      end
      cyc();
    end
    rst_sys = 0; set_req(0);
    chk("R10 reset wins esr", esr, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule